// File: doc/BRIEF.md
# Bit-Slice Twiddle Accumulator

This block computes the discrete Fourier transform of one binary bit slice, using adders only. The slice arrives one bit per clock, with sample index n running from 0 to N-1. A bit of one adds the complex twiddle vector W^(kn) to a pair of signed accumulators. A bit of zero adds nothing. Once all N bits of a frequency index k have arrived, the finished complex coefficient is registered on the output and marked by a one-cycle strobe. The accumulators then clear, and the block moves on to index k+1.

The block owns no twiddle storage. It drives a twiddle table address and expects the real and imaginary parts back one clock later, as a synchronous ROM returns them. The address is never produced by a multiplier. It comes from a phase register that advances by k, modulo N, on every accepted sample, and it is forced back to 0 when a new k begins. Samples are qualified by a valid input, so the source can stall at any cycle.

Top module: `bsdft_slice_acc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0, out_re, out_im and out_k are 0, and tw_addr is 0.
- R2: In the cycle where sample n of index k is offered (smp_valid high), tw_addr equals (k*n) mod N. The twiddle data for that address must be on tw_re/tw_im in the following cycle.
- R3: For each index k, the coefficient equals the sum, over every n whose slice bit is 1, of the sign-extended twiddle value returned for address (k*n) mod N. This holds separately for the real part and the imaginary part. Both are 32-bit two's complement, with no truncation or rounding.
- R4: out_valid is high for exactly one cycle per coefficient. That cycle is the second clock cycle after the edge that accepts sample n = N-1. In every other cycle out_valid is 0.
- R5: Each coefficient depends only on the N samples of its own index. Nothing carries over from the previous coefficient.
- R6: out_k gives the index of the coefficient being strobed. Indices run 0, 1, ..., N-1 and then wrap back to 0.
- R7: A cycle with smp_valid low consumes no sample. tw_addr, the sample position and the partial sums are unchanged.
- R8: Between strobes, out_re, out_im and out_k hold the last coefficient.
- R9: Sums larger than one twiddle's 17-bit range are represented exactly. An all-ones slice at k = 0 yields N times twiddle entry 0, and the most negative twiddle value accumulates correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A slice bit is offered this cycle |
| smp_bit | input | 1 | The slice bit for the current sample index |
| tw_addr | output | log2(N) | Twiddle table address for the offered sample |
| tw_re | input | 17 | Real twiddle part, signed Q1.15, one cycle after tw_addr |
| tw_im | input | 17 | Imaginary twiddle part, signed Q1.15, one cycle after tw_addr |
| out_valid | output | 1 | One-cycle strobe: a coefficient is on out_re/out_im |
| out_re | output | 32 | Real part of the coefficient, signed |
| out_im | output | 32 | Imaginary part of the coefficient, signed |
| out_k | output | log2(N) | Frequency index of the coefficient |

## Verification
A phase register that is off by one step shows up on tw_addr in the very next offered sample. The bench compares the address on every cycle, so the error is seen at once. An accumulator that is not cleared at a k boundary, or a twiddle word paired with the wrong sample, stays hidden until the next strobe. It then appears as a wrong coefficient value. A sample or end-of-index marker lost in the two-stage pipeline shows up as a strobe one cycle early or late, or as a strobe that never comes. The bench models the expected outputs cycle by cycle, so it catches a misplaced strobe in the cycle where it goes wrong.

// File: rtl/bsdft_pkg.sv
package bsdft_pkg;
  localparam int unsigned TW_WIDTH  = 17;
  localparam int unsigned ACC_WIDTH = 32;

  // Returns (a + b) mod n, given a < n and b < n.
  function automatic int unsigned mod_add(int unsigned a, int unsigned b, int unsigned n);
    int unsigned s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // Moves an index one step forward, wrapping from n-1 to 0.
  function automatic int unsigned mod_inc(int unsigned a, int unsigned n);
    return (a == n - 1) ? 0 : a + 1;
  endfunction
endpackage

// File: rtl/bsdft_index_gen.sv
module bsdft_index_gen #(
  parameter int unsigned N  = 1024,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic [AW-1:0] tw_addr,
  output logic [AW-1:0] cur_k,
  output logic          take,
  output logic          take_last
);
  import bsdft_pkg::*;

  logic [AW-1:0] n_q, k_q, ph_q;
  logic [AW-1:0] n_nx, k_nx, ph_nx;
  logic          at_end;

  assign at_end    = (n_q == AW'(N - 1));
  assign take      = smp_valid;
  assign take_last = smp_valid && at_end;
  assign tw_addr   = ph_q;
  assign cur_k     = k_q;

  always_comb begin
    n_nx  = n_q;
    k_nx  = k_q;
    ph_nx = ph_q;
    if (smp_valid) begin
      if (at_end) begin
        n_nx  = '0;
        ph_nx = '0;
        k_nx  = AW'(mod_inc(int'(k_q), N));
      end else begin
        n_nx  = AW'(mod_inc(int'(n_q), N));
        ph_nx = AW'(mod_add(int'(ph_q), int'(k_q), N));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q  <= '0;
      k_q  <= '0;
      ph_q <= '0;
    end else begin
      n_q  <= n_nx;
      k_q  <= k_nx;
      ph_q <= ph_nx;
    end
  end
endmodule

// File: rtl/bsdft_cplx_acc.sv
module bsdft_cplx_acc #(
  parameter int unsigned AW    = 10,
  parameter int unsigned TW_W  = 17,
  parameter int unsigned ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    take_last,
  input  logic                    smp_bit,
  input  logic [AW-1:0]           cur_k,
  input  logic signed [TW_W-1:0]  tw_re,
  input  logic signed [TW_W-1:0]  tw_im,
  output logic signed [ACC_W-1:0] acc_re,
  output logic signed [ACC_W-1:0] acc_im,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_re,
  output logic signed [ACC_W-1:0] out_im,
  output logic [AW-1:0]           out_k
);
  localparam int unsigned EXT = ACC_W - TW_W;

  // Stage 1 holds the sample while the table read completes.
  logic          d_valid, d_bit, d_last;
  logic [AW-1:0] d_k;
  logic signed [ACC_W-1:0] term_re, term_im, sum_re, sum_im;

  function automatic logic signed [ACC_W-1:0] gate_ext(logic en, logic signed [TW_W-1:0] v);
    return en ? {{EXT{v[TW_W-1]}}, v} : '0;
  endfunction

  assign term_re = gate_ext(d_bit, tw_re);
  assign term_im = gate_ext(d_bit, tw_im);
  assign sum_re  = acc_re + term_re;
  assign sum_im  = acc_im + term_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid   <= 1'b0;
      d_bit     <= 1'b0;
      d_last    <= 1'b0;
      d_k       <= '0;
      acc_re    <= '0;
      acc_im    <= '0;
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      out_k     <= '0;
    end else begin
      d_valid   <= take;
      d_bit     <= smp_bit;
      d_last    <= take_last;
      d_k       <= cur_k;
      out_valid <= d_valid && d_last;
      if (d_valid) begin
        if (d_last) begin
          out_re <= sum_re;
          out_im <= sum_im;
          out_k  <= d_k;
          acc_re <= '0;
          acc_im <= '0;
        end else begin
          acc_re <= sum_re;
          acc_im <= sum_im;
        end
      end
    end
  end
endmodule

// File: rtl/bsdft_slice_acc.sv
module bsdft_slice_acc #(
  parameter int unsigned N     = 1024,
  parameter int unsigned TW_W  = bsdft_pkg::TW_WIDTH,
  parameter int unsigned ACC_W = bsdft_pkg::ACC_WIDTH,
  localparam int unsigned AW   = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic                    smp_bit,
  output logic [AW-1:0]           tw_addr,
  input  logic signed [TW_W-1:0]  tw_re,
  input  logic signed [TW_W-1:0]  tw_im,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_re,
  output logic signed [ACC_W-1:0] out_im,
  output logic [AW-1:0]           out_k
);
  // Internal events, named so the checker can observe them.
  logic                    take;
  logic                    take_last;
  logic [AW-1:0]           cur_k;
  logic signed [ACC_W-1:0] acc_re_w;
  logic signed [ACC_W-1:0] acc_im_w;

  bsdft_index_gen #(.N(N), .AW(AW)) u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .tw_addr   (tw_addr),
    .cur_k     (cur_k),
    .take      (take),
    .take_last (take_last)
  );

  bsdft_cplx_acc #(.AW(AW), .TW_W(TW_W), .ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_last (take_last),
    .smp_bit   (smp_bit),
    .cur_k     (cur_k),
    .tw_re     (tw_re),
    .tw_im     (tw_im),
    .acc_re    (acc_re_w),
    .acc_im    (acc_im_w),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_k     (out_k)
  );
endmodule

// File: rtl/bsdft_slice_acc_chk.sv
module bsdft_slice_acc_chk #(
  parameter int unsigned AW    = 10,
  parameter int unsigned ACC_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_valid,
  input logic [AW-1:0]           tw_addr,
  input logic                    take_last,
  input logic                    out_valid,
  input logic signed [ACC_W-1:0] out_re,
  input logic signed [ACC_W-1:0] out_im,
  input logic [AW-1:0]           out_k,
  input logic signed [ACC_W-1:0] acc_re,
  input logic signed [ACC_W-1:0] acc_im
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R4
  AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    take_last |=> ##1 out_valid); // R4
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    take_last |=> (tw_addr == '0)); // R2
  AST_STALL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(tw_addr)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_re) && $stable(out_im) && $stable(out_k))); // R8
  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (acc_re == '0 && acc_im == '0)); // R5
endmodule

bind bsdft_slice_acc bsdft_slice_acc_chk #(.AW(AW), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .tw_addr   (tw_addr),
  .take_last (take_last),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im),
  .out_k     (out_k),
  .acc_re    (acc_re_w),
  .acc_im    (acc_im_w)
);

// File: tb/test_bsdft_slice_acc.sv
module test_bsdft_slice_acc;
  localparam int N  = 8;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_bit = 1'b0;
  logic [AW-1:0] tw_addr;
  logic signed [16:0] tw_re, tw_im;
  logic out_valid;
  logic signed [31:0] out_re, out_im;
  logic [AW-1:0] out_k;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  bsdft_slice_acc #(.N(N)) i_bsdft_slice_acc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bit(smp_bit),
    .tw_addr(tw_addr), .tw_re(tw_re), .tw_im(tw_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_k(out_k)
  );

  // Twiddle table contents. Entry 0 and entry 4 hold the two extremes of the range.
  function automatic int tbl_re(int i);
    if (i == 0) return 65535;
    if (i == 4) return -65536;
    return ((i * 12345) % 60000) - 30000;
  endfunction
  function automatic int tbl_im(int i);
    if (i == 4) return 65535;
    if (i == 2) return -65536;
    return 20000 - ((i * 7919) % 50000);
  endfunction

  // Synchronous table read, one cycle of latency.
  always @(posedge clk) begin
    tw_re <= 17'(tbl_re(int'(tw_addr)));
    tw_im <= 17'(tbl_im(int'(tw_addr)));
  end

  task automatic chk(string tag, bit ok, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model: position, index and partial sums, updated behaviourally.
  int mn, mk, cyc, n_coef;
  longint sre, sim;
  bit stalled;
  int     q_due[$];
  longint q_re[$], q_im[$];
  int     q_k[$];
  string  q_tag[$];
  longint hold_re, hold_im;
  int     hold_k;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mn = 0; mk = 0; cyc = 0; sre = 0; sim = 0; stalled = 1'b0; n_coef = 0;
    end else begin
      cyc++;
      stalled = !smp_valid;
      if (smp_valid) begin
        if (smp_bit) begin
          sre += tbl_re((mk * mn) % N);
          sim += tbl_im((mk * mn) % N);
        end
        if (mn == N - 1) begin
          q_due.push_back(cyc + 1);
          q_re.push_back(sre);
          q_im.push_back(sim);
          q_k.push_back(mk);
          q_tag.push_back(n_coef == 0 ? "R9" : (n_coef == 1 ? "R5" : "R3"));
          n_coef++;
          sre = 0; sim = 0; mn = 0;
          mk = (mk + 1) % N;
        end else begin
          mn++;
        end
      end
    end
  end

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && cyc > 0) begin
      chk(stalled ? "R7" : "R2", tw_addr == AW'((mk * mn) % N), tw_addr, (mk * mn) % N);
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        chk("R4", out_valid == 1'b1, out_valid, 1);
        chk(q_tag[0], out_re == 32'(q_re[0]), out_re, q_re[0]);
        chk(q_tag[0], out_im == 32'(q_im[0]), out_im, q_im[0]);
        chk("R6", out_k == AW'(q_k[0]), out_k, q_k[0]);
        hold_re = q_re[0]; hold_im = q_im[0]; hold_k = q_k[0];
        void'(q_due.pop_front()); void'(q_re.pop_front()); void'(q_im.pop_front());
        void'(q_k.pop_front()); void'(q_tag.pop_front());
      end else begin
        chk("R4", out_valid == 1'b0, out_valid, 0);
        chk("R8", out_re == 32'(hold_re) && out_im == 32'(hold_im) && out_k == AW'(hold_k),
            out_re, hold_re);
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] lfsr;
    hold_re = 0; hold_im = 0; hold_k = 0;
    lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk("R1", out_valid == 1'b0, out_valid, 0);
    chk("R1", out_re == 0 && out_im == 0, out_re, 0);
    chk("R1", out_k == 0 && tw_addr == 0, tw_addr, 0);
    rst_n = 1'b1;
    // R9: all-ones slice at k = 0
    for (int i = 0; i < N; i++) begin
      @(negedge clk); smp_valid = 1'b1; smp_bit = 1'b1;
    end
    // R5: all-zero slice right after a large coefficient
    for (int i = 0; i < N; i++) begin
      @(negedge clk); smp_valid = 1'b1; smp_bit = 1'b0;
    end
    // R3/R6/R7: pseudo-random bits with stalls, through the k wrap and beyond
    for (int i = 0; i < 2 * N * N + 3 * N; i++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      smp_valid = (lfsr[2:0] != 3'd0);
      smp_bit   = lfsr[6];
    end
    @(negedge clk); smp_valid = 1'b0; smp_bit = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", q_due.size() == 0, q_due.size(), 0);
    finish_run();
  end
endmodule